// File: doc/BRIEF.md
# Watchdog Reset Sequencer

This block turns a watchdog overflow strobe into an orderly internal reset. It checks the external bus first. When a bus cycle is in flight, the cycle either runs to its end or is cut short, depending on the READY level seen once the wait states have elapsed. Only then does the internal reset start. The reset lasts a fixed, parameterised number of clock cycles. It ends with a one-cycle strobe that captures the hardware configuration field.

While the internal reset is active, the block can pull the external reset pin low. It does this only when bidirectional mode is selected and the RPD level is high. The RPD level never changes the sequence timing. A sticky reset-out flag rises with the internal reset and stays high until software releases it. Overflow strobes that arrive while a sequence is already running are dropped.

Top module: `wdt_rst_seq`

## Requirements
- R1: After `rst_n` is released, `int_rst`, `rst_out`, `cfg_strobe`, `pin_drive_en` and `bus_abort` are 0 and `cfg_q` is all zeros.
- R2: An overflow sampled while idle with `bus_active` low raises `int_rst` on the next clock edge.
- R3: An overflow sampled while `bus_active` is high holds `int_rst` low while the bus cycle remains in flight. `int_rst` rises on the edge after `bus_active` is sampled low.
- R4: While waiting on the bus, `bus_ws_done`=1 with `bus_rdy_used`=1 and `bus_rdy_n`=1 (READY inactive high) asserts `bus_abort` in that same cycle. `int_rst` rises on the next edge.
- R5: When the cycle does not use READY (`bus_rdy_used`=0), or READY is low (`bus_rdy_n`=0) at `bus_ws_done`, there is no abort. The block waits for `bus_active` to fall.
- R6: `int_rst` stays high for exactly `RST_CYCLES` consecutive cycles (default 1024).
- R7: `cfg_strobe` is high for exactly one cycle, in the cycle right after `int_rst` falls. `cfg_q` then holds the `cfg_in` value sampled in that strobe cycle.
- R8: `pin_drive_en` is 1 only while `int_rst` is 1, `bidir_en` is 1 and `rpd_hi` is 1. Otherwise it is 0.
- R9: `rst_out` rises together with `int_rst` and stays high until `rst_out_clr` is sampled high while idle. A clear during the sequence has no effect.
- R10: Overflow strobes during a running sequence start no second reset.
- R11: The RPD level does not change when the reset starts or how long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| bus_active | input | 1 | External bus cycle in flight |
| bus_rdy_used | input | 1 | Current bus cycle is READY-controlled |
| bus_rdy_n | input | 1 | READY pin level (active low) |
| bus_ws_done | input | 1 | Programmed wait states have elapsed |
| rpd_hi | input | 1 | RPD pin level is high |
| bidir_en | input | 1 | Bidirectional reset mode selected |
| rst_out_clr | input | 1 | Software release of reset-out |
| cfg_in | input | CFG_W | Configuration field sampled at the end of reset |
| int_rst | output | 1 | Internal reset |
| bus_abort | output | 1 | Abort the running bus cycle |
| pin_drive_en | output | 1 | Drive the reset input pin low |
| cfg_strobe | output | 1 | One-cycle configuration latch strobe |
| cfg_q | output | CFG_W | Latched configuration field |
| rst_out | output | 1 | Sticky reset-out indication |

## Verification
The assertions check on every cycle the relations that hold between ports:
- an abort is always followed by the internal reset;
- the reset only ever starts from a clear or aborted bus;
- each reset run has exactly the set length, followed by a single strobe;
- reset-out covers the internal reset and falls only after a release;
- the pin is never driven outside an allowed reset.

The scenarios have to show the rest: waiting on a READY-low or READY-less cycle instead of aborting, dropping overflows during a sequence, the latched configuration value, and identical timing with RPD high and low.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_BUS = 2'd1,
      ST_RESET    = 2'd2,
      ST_LATCH    = 2'd3
   } wrs_state_e;
endpackage

// File: rtl/wrs_bus_gate.sv
module wrs_bus_gate (
   input  logic in_wait,
   input  logic bus_active,
   input  logic rdy_used,
   input  logic rdy_n,
   input  logic ws_done,
   output logic abort,
   output logic bus_clear
);
   logic rdy_blocked;

   // READY sampled inactive after the wait states cuts the cycle short
   assign rdy_blocked = rdy_used & rdy_n & ws_done;
   assign abort       = in_wait & bus_active & rdy_blocked;
   assign bus_clear   = ~bus_active | rdy_blocked;
endmodule

// File: rtl/wrs_span_timer.sv
module wrs_span_timer #(
   parameter int unsigned SPAN = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CNT_W = (SPAN > 2) ? $clog2(SPAN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SPAN - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign done = run & (cnt_q == LAST);

   // R6
   span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= LAST));
endmodule

// File: rtl/wrs_seq_fsm.sv
module wrs_seq_fsm
   import wrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdt_ovf,
   input  logic       bus_active,
   input  logic       bus_clear,
   input  logic       span_done,
   output wrs_state_e state
);
   wrs_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (wdt_ovf) st_d = bus_active ? ST_WAIT_BUS : ST_RESET;
         ST_WAIT_BUS: if (bus_clear) st_d = ST_RESET;
         ST_RESET:    if (span_done) st_d = ST_LATCH;
         ST_LATCH:    st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state = st_q;

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RESET && !span_done) |=> (st_q == ST_RESET));
endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
   import wrs_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 1024,
   parameter int unsigned CFG_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_ovf,
   input  logic             bus_active,
   input  logic             bus_rdy_used,
   input  logic             bus_rdy_n,
   input  logic             bus_ws_done,
   input  logic             rpd_hi,
   input  logic             bidir_en,
   input  logic             rst_out_clr,
   input  logic [CFG_W-1:0] cfg_in,
   output logic             int_rst,
   output logic             bus_abort,
   output logic             pin_drive_en,
   output logic             cfg_strobe,
   output logic [CFG_W-1:0] cfg_q,
   output logic             rst_out
);
   generate
      if (RST_CYCLES < 2) begin : g_bad_span
         $error("RST_CYCLES must be at least 2");
      end
      if (CFG_W < 1 || CFG_W > 16) begin : g_bad_cfg
         $error("CFG_W must lie in 1..16");
      end
   endgenerate

   wrs_state_e state;
   logic       bus_clear;
   logic       span_done;
   logic       hold_q;
   logic [CFG_W-1:0] cfg_r;

   wrs_bus_gate u_gate (
      .in_wait   (state == ST_WAIT_BUS),
      .bus_active(bus_active),
      .rdy_used  (bus_rdy_used),
      .rdy_n     (bus_rdy_n),
      .ws_done   (bus_ws_done),
      .abort     (bus_abort),
      .bus_clear (bus_clear)
   );

   wrs_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdt_ovf   (wdt_ovf),
      .bus_active(bus_active),
      .bus_clear (bus_clear),
      .span_done (span_done),
      .state     (state)
   );

   wrs_span_timer #(.SPAN(RST_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_RESET),
      .done (span_done)
   );

   assign int_rst      = (state == ST_RESET);
   assign cfg_strobe   = (state == ST_LATCH);
   assign pin_drive_en = int_rst & bidir_en & rpd_hi;

   // sticky reset-out, released by software only once idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               hold_q <= 1'b0;
      else if (int_rst)                         hold_q <= 1'b1;
      else if (state == ST_IDLE && rst_out_clr) hold_q <= 1'b0;
   end
   assign rst_out = hold_q | int_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_r <= '0;
      else if (cfg_strobe) cfg_r <= cfg_in;
   end
   assign cfg_q = cfg_r;

   // checker-only run length counter for R6
   int unsigned run_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len_q <= 0;
      else if (int_rst) run_len_q <= run_len_q + 1;
      else              run_len_q <= 0;
   end

   // R4
   abort_then_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_abort |=> int_rst);
   // R3
   start_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_rst) |-> $past(!bus_active || bus_abort));
   // R6
   span_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> (run_len_q == RST_CYCLES));
   // R7
   strobe_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> cfg_strobe);
   // R7
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_strobe |=> !cfg_strobe);
   // R8
   pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_drive_en |-> (int_rst && bidir_en && rpd_hi));
   // R9
   out_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_rst |-> rst_out);
   // R9
   out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> $past(rst_out_clr));
endmodule

// File: tb/sim_wdt_rst_seq.sv
`timescale 1ns/1ps
module sim_wdt_rst_seq;
   localparam int unsigned N = 32;
   localparam int unsigned W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wdt_ovf = 0, bus_active = 0, bus_rdy_used = 0, bus_rdy_n = 0;
   logic bus_ws_done = 0, rpd_hi = 0, bidir_en = 0, rst_out_clr = 0;
   logic [W-1:0] cfg_in = '0;
   logic int_rst, bus_abort, pin_drive_en, cfg_strobe, rst_out;
   logic [W-1:0] cfg_q;

   always #4 clk = ~clk;

   wdt_rst_seq #(.RST_CYCLES(N), .CFG_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .bus_active(bus_active),
      .bus_rdy_used(bus_rdy_used), .bus_rdy_n(bus_rdy_n),
      .bus_ws_done(bus_ws_done), .rpd_hi(rpd_hi), .bidir_en(bidir_en),
      .rst_out_clr(rst_out_clr), .cfg_in(cfg_in), .int_rst(int_rst),
      .bus_abort(bus_abort), .pin_drive_en(pin_drive_en),
      .cfg_strobe(cfg_strobe), .cfg_q(cfg_q), .rst_out(rst_out));

   typedef struct {
      int           start;
      logic [W-1:0] cfg;
      string        req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0, n_fail = 0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: measures each reset episode and compares with the scoreboard
   initial begin
      int   st = -1;
      bit   prev = 0;
      bit   cfg_due = 0;
      exp_t e;
      forever begin
         @(negedge clk); #1;
         if (cfg_due) begin
            chk(cfg_q == e.cfg, {"R7 cfg ", e.req}, int'(cfg_q), int'(e.cfg));
            cfg_due = 0;
         end
         if (rst_n && int_rst && !prev) st = cyc;
         if (rst_n && cfg_strobe) begin
            chk(cyc - st == N, {"R6 length ", e.req}, cyc - st, N);
            if (exp_q.size() == 0) begin
               chk(0, "R10 unexpected reset", st, -1);
            end else begin
               e = exp_q.pop_front();
               chk(st == e.start, {"start ", e.req}, st, e.start);
               cfg_due = 1;
            end
         end
         prev = int_rst;
      end
   end

   task automatic step(); @(negedge clk); #1; endtask

   task automatic pulse_ovf(output int c);
      @(negedge clk); wdt_ovf = 1; c = cyc;
      @(negedge clk); wdt_ovf = 0; #1;
   endtask

   task automatic wait_done();
      do step(); while (!cfg_strobe);
      step();
   endtask

   task automatic push(input int start, input string req);
      exp_t e;
      e.start = start; e.cfg = cfg_in; e.req = req;
      exp_q.push_back(e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      int c, d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      // R1
      chk(!int_rst && !rst_out && !cfg_strobe && !pin_drive_en && !bus_abort,
          "R1 outputs idle", int'({int_rst, rst_out, cfg_strobe, pin_drive_en}), 0);
      chk(cfg_q == '0, "R1 cfg_q", int'(cfg_q), 0);

      // R2 direct start, pin driven (R8), rst_out (R9)
      bidir_en = 1; rpd_hi = 1; cfg_in = 5'h15;
      pulse_ovf(c);
      push(c + 1, "R2");
      chk(int_rst == 1, "R2 rise", int_rst, 1);
      chk(pin_drive_en == 1, "R8 drive bidir rpd high", pin_drive_en, 1);
      chk(rst_out == 1, "R9 rst_out with reset", rst_out, 1);
      @(negedge clk); rst_out_clr = 1;          // R9 clear mid-sequence ignored
      @(negedge clk); rst_out_clr = 0;
      // R10 overflow mid-sequence ignored
      @(negedge clk); wdt_ovf = 1;
      @(negedge clk); wdt_ovf = 0;
      wait_done();
      repeat (4) step();
      chk(!int_rst, "R10 no second reset", int_rst, 0);
      chk(rst_out == 1, "R9 rst_out sticky", rst_out, 1);
      @(negedge clk); rst_out_clr = 1;
      @(negedge clk); rst_out_clr = 0; #1;
      chk(rst_out == 0, "R9 released", rst_out, 1'b0);

      // R3/R5 bus cycle without READY: wait for completion
      cfg_in = 5'h0A; bidir_en = 0;
      @(negedge clk); bus_active = 1; bus_rdy_used = 0;
      pulse_ovf(c);
      @(negedge clk); bus_ws_done = 1; bus_rdy_n = 1; #1;
      chk(!bus_abort, "R5 no abort without READY", bus_abort, 0);
      step(); step();
      chk(!int_rst, "R3 held while bus busy", int_rst, 0);
      @(negedge clk); bus_active = 0; bus_ws_done = 0; d = cyc;
      push(d + 1, "R3");
      step();
      chk(int_rst == 1, "R3 start after bus end", int_rst, 1);
      chk(!pin_drive_en, "R8 no drive when unidirectional", pin_drive_en, 0);
      wait_done();

      // R5 READY low at wait-state end: completes, no abort
      cfg_in = 5'h1F; bidir_en = 1; rpd_hi = 0;
      @(negedge clk); bus_active = 1; bus_rdy_used = 1; bus_rdy_n = 1;
      pulse_ovf(c);
      @(negedge clk); bus_ws_done = 1; bus_rdy_n = 0; #1;
      chk(!bus_abort, "R5 READY low no abort", bus_abort, 0);
      step();
      chk(!int_rst, "R5 waits for cycle end", int_rst, 0);
      @(negedge clk); bus_active = 0; bus_ws_done = 0; d = cyc;
      push(d + 1, "R5");
      step();
      chk(int_rst == 1 && !pin_drive_en, "R8/R11 rpd low no drive, same start",
          int'({int_rst, pin_drive_en}), 2);
      wait_done();

      // R4 READY high at wait-state end: abort
      cfg_in = 5'h03; rpd_hi = 1;
      @(negedge clk); bus_active = 1; bus_rdy_used = 1; bus_rdy_n = 1;
      pulse_ovf(c);
      step();
      chk(!bus_abort && !int_rst, "R4 no abort before wait states", bus_abort, 0);
      @(negedge clk); bus_ws_done = 1; d = cyc; #1;
      chk(bus_abort == 1, "R4 abort asserted", bus_abort, 1);
      push(d + 1, "R4");
      @(negedge clk); bus_ws_done = 0; bus_active = 0; #1;
      chk(int_rst == 1, "R4 reset after abort", int_rst, 1);
      chk(pin_drive_en == 1, "R8 drive again", pin_drive_en, 1);
      wait_done();

      repeat (3) step();
      chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule